// File: doc/BRIEF.md
# Three-Level Carrier PWM Gate Generator

This block produces the gate commands for one phase leg of a three-level neutral-clamped inverter. An internal up/down counter forms two triangular carriers that rise and fall together. The upper carrier covers the positive half of the reference range and the lower carrier covers the negative half. A signed reference sample is taken at each carrier peak and held for one full carrier period. Comparing the held sample with both carriers selects one of three regions. The region drives the positive rail, the neutral tap or the negative rail onto the leg output.

Each region maps to a pair of main switch commands and their logical inverses, which gives four gate outputs. Every gate output is delayed by a programmable number of cycles when it turns on, and turns off without added delay. As a result, the two gates of a complementary pair are both off for the dead time on every hand-over. A two-bit level code tells the surrounding control which rail the leg is connected to. The code changes only when the four gates form a complete, settled pattern.

Top module: `npc_pwm_gen`

## Requirements
- R1: The carrier counter runs 0,1,…,P,P−1,…,1 and repeats, giving a period of 2P cycles, where P is `period_i`. The upper carrier equals the count. The lower carrier equals the count minus P. A reference of ±P is therefore full scale.
- R2: When the held reference is greater than the upper carrier, both main gates `s1_o` and `s2_o` are on, both complements are off, and `level_o` is 2'b01.
- R3: When the held reference lies between the two carriers, with both ends included, `s2_o` and `s1n_o` are on, `s1_o` and `s2n_o` are off, and `level_o` is 2'b00.
- R4: When the held reference is less than the lower carrier, `s1n_o` and `s2n_o` are on, both main gates are off, and `level_o` is 2'b11.
- R5: A main gate and its complement are never on in the same cycle.
- R6: A gate turns on `dead_i` cycles after its command, and turns off in the cycle its command drops. On each hand-over within a complementary pair, both gates of the pair are off for exactly `dead_i` cycles.
- R7: `level_o` changes only to the code of a complete gate pattern. While a pair is in its dead time, the previous code is kept. The value 2'b10 never appears.
- R8: The reference is sampled only at the carrier peak, when the count equals P. Changes of `ref_i` at other times have no effect until the next peak.
- R9: While reset is asserted, all four gates are off and `level_o` is 2'b00. After reset is released, the counter starts at 0 and counts upward, and the held reference is 0.
- R10: A reference above +P keeps the leg at the positive level for the whole period. A reference below −P keeps it at the negative level for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | REF_W | Signed reference sample |
| period_i | input | REF_W-1 | Carrier peak value P |
| dead_i | input | DT_W | Dead time in cycles |
| s1_o | output | 1 | Outer main switch gate |
| s2_o | output | 1 | Inner main switch gate |
| s1n_o | output | 1 | Complement of the outer gate |
| s2n_o | output | 1 | Complement of the inner gate |
| level_o | output | 2 | Leg level: 01 positive, 00 neutral, 11 negative |

## Verification
The bench builds the block with its default widths: a 12-bit reference, an 11-bit period and an 8-bit dead time. It drives carrier peaks of 4 and 8, so a whole carrier period takes 8 or 16 cycles, and the time spent at each level can be counted over one period and compared with values worked out by hand. Dead times of 0 to 3 stay shorter than every pulse in those cases, so the count at each level does not depend on the dead time. Toggling the reference at half the rate of the even carrier period makes the peak sampling visible. References of ±P and beyond exercise the saturation edges of the decision.

// File: rtl/npc_pwm_pkg.sv
package npc_pwm_pkg;
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } level_e;

  // gate vector bit positions
  localparam int unsigned G_S1  = 0;
  localparam int unsigned G_S2  = 1;
  localparam int unsigned G_S1N = 2;
  localparam int unsigned G_S2N = 3;
  localparam int unsigned N_GATES = 4;
endpackage

// File: rtl/npc_carrier.sv
module npc_carrier #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             peak_o
);
  logic             up_q;
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign peak_o = up_q && (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= 1'b1;
      cnt_q <= '0;
    end else if (up_q) begin
      if (cnt_q >= period_i) begin
        up_q  <= 1'b0;
        cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        up_q  <= 1'b1;
        cnt_q <= (period_i == '0) ? '0 : CNT_W'(1);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/npc_region.sv
module npc_region
  import npc_pwm_pkg::*;
#(
  parameter int unsigned REF_W = 12,
  localparam int unsigned CNT_W = REF_W - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    peak_i,
  output logic [N_GATES-1:0]      cmd_o
);
  logic signed [REF_W-1:0] ref_q;
  logic signed [REF_W-1:0] upper, lower;
  logic                    is_pos, is_neg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ref_q <= '0;
    else if (peak_i) ref_q <= ref_i;
  end

  assign upper  = $signed({1'b0, cnt_i});
  assign lower  = upper - $signed({1'b0, period_i});
  assign is_pos = ref_q > upper;
  assign is_neg = ref_q < lower;

  always_comb begin
    cmd_o        = '0;
    cmd_o[G_S1]  = is_pos;
    cmd_o[G_S2]  = !is_neg;
    cmd_o[G_S1N] = !is_pos;
    cmd_o[G_S2N] = is_neg;
  end
endmodule

// File: rtl/npc_deadband.sv
module npc_deadband #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            gate_o
);
  logic [DT_W-1:0] hold_q;
  logic            gate_q;

  assign gate_o = gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      gate_q <= 1'b0;
    end else if (!cmd_i) begin
      hold_q <= '0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= (hold_q >= dead_i);
      if (hold_q != {DT_W{1'b1}}) hold_q <= hold_q + 1'b1;
    end
  end
endmodule

// File: rtl/npc_level_enc.sv
module npc_level_enc
  import npc_pwm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_GATES-1:0] gates_i,
  output logic [1:0]         level_o
);
  level_e lvl_q;

  assign level_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LVL_ZERO;
    end else begin
      unique case (gates_i)
        4'b0011: lvl_q <= LVL_POS;   // s1, s2
        4'b0110: lvl_q <= LVL_ZERO;  // s2, s1n
        4'b1100: lvl_q <= LVL_NEG;   // s1n, s2n
        default: lvl_q <= lvl_q;     // dead time in progress
      endcase
    end
  end
endmodule

// File: rtl/npc_pwm_gen.sv
module npc_pwm_gen
  import npc_pwm_pkg::*;
#(
  parameter int unsigned REF_W = 12,
  parameter int unsigned DT_W  = 8,
  localparam int unsigned CNT_W = REF_W - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [DT_W-1:0]         dead_i,
  output logic                    s1_o,
  output logic                    s2_o,
  output logic                    s1n_o,
  output logic                    s2n_o,
  output logic [1:0]              level_o
);
  logic [CNT_W-1:0]   cnt;
  logic               peak;
  logic [N_GATES-1:0] cmd;
  logic [N_GATES-1:0] gates;

  npc_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period_i),
    .cnt_o   (cnt),
    .peak_o  (peak)
  );

  npc_region #(.REF_W(REF_W)) u_region (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_i   (ref_i),
    .period_i(period_i),
    .cnt_i   (cnt),
    .peak_i  (peak),
    .cmd_o   (cmd)
  );

  for (genvar g = 0; g < N_GATES; g++) begin : g_db
    npc_deadband #(.DT_W(DT_W)) u_db (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cmd_i (cmd[g]),
      .dead_i(dead_i),
      .gate_o(gates[g])
    );
  end

  npc_level_enc u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gates_i(gates),
    .level_o(level_o)
  );

  assign s1_o  = gates[G_S1];
  assign s2_o  = gates[G_S2];
  assign s1n_o = gates[G_S1N];
  assign s2n_o = gates[G_S2N];
endmodule

// File: rtl/npc_pwm_checker.sv
module npc_pwm_checker #(
  parameter int unsigned DT_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            s1_o,
  input logic            s2_o,
  input logic            s1n_o,
  input logic            s2n_o,
  input logic [1:0]      level_o,
  input logic [DT_W-1:0] dead_i
);
  assert_no_shoot_s1_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s1_o && s1n_o));

  assert_no_shoot_s2_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s2_o && s2n_o));

  assert_no_bad_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o != 2'b10);

  assert_code_after_pattern_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_o) |->
      ((level_o == 2'b01) && $past(s1_o && s2_o && !s1n_o && !s2n_o)) ||
      ((level_o == 2'b00) && $past(!s1_o && s2_o && s1n_o && !s2n_o)) ||
      ((level_o == 2'b11) && $past(!s1_o && !s2_o && s1n_o && s2n_o)));

  assert_dead_gap_s1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(s1_o) && (dead_i != '0) && $stable(dead_i)) |-> !$past(s1n_o));

  assert_dead_gap_s1n_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(s1n_o) && (dead_i != '0) && $stable(dead_i)) |-> !$past(s1_o));
endmodule

bind npc_pwm_gen npc_pwm_checker #(.DT_W(DT_W)) u_npc_pwm_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .s1_o   (s1_o),
  .s2_o   (s2_o),
  .s1n_o  (s1n_o),
  .s2n_o  (s2n_o),
  .level_o(level_o),
  .dead_i (dead_i)
);

// File: tb/npc_pwm_gen_tb.sv
`timescale 1ns/1ps
module npc_pwm_gen_tb_top;
  localparam int REF_W = 12;
  localparam int DT_W  = 8;
  localparam int CNT_W = REF_W - 1;
  localparam int NV    = 8;
  // ref, P, dead, expected cycles at +, 0, - over one period
  localparam int TBL [NV][6] = '{
    '{ 4, 8, 3,  7,  9,  0},
    '{ 0, 8, 2,  0, 16,  0},
    '{-4, 8, 3,  0,  9,  7},
    '{ 8, 8, 0, 15,  1,  0},
    '{-8, 8, 0,  0,  1, 15},
    '{ 9, 8, 1, 16,  0,  0},
    '{-9, 8, 1,  0,  0, 16},
    '{ 2, 4, 1,  3,  5,  0}
  };

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic signed [REF_W-1:0] ref_i = '0;
  logic [CNT_W-1:0]        period_i = CNT_W'(8);
  logic [DT_W-1:0]         dead_i = '0;
  logic s1_o, s2_o, s1n_o, s2n_o;
  logic [1:0] level_o;

  int checks = 0;
  int errors = 0;
  int shoot  = 0;
  bit done   = 1'b0;
  bit toggle_on = 1'b0;

  always #2.5 clk_i = ~clk_i;

  npc_pwm_gen #(.REF_W(REF_W), .DT_W(DT_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .period_i(period_i),
    .dead_i(dead_i), .s1_o(s1_o), .s2_o(s2_o), .s1n_o(s1n_o), .s2n_o(s2n_o),
    .level_o(level_o)
  );

  // per-cycle shoot-through and code monitor (R5, R7)
  always @(negedge clk_i) begin
    if (rst_ni && ((s1_o && s1n_o) || (s2_o && s2n_o) || level_o == 2'b10)) shoot++;
  end

  // R8 stimulus: reference flips every cycle
  always @(posedge clk_i) begin
    if (toggle_on) ref_i <= (ref_i == 12'sd9) ? -12'sd9 : 12'sd9;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic count_levels(input int n, output int np, output int nz, output int nn);
    np = 0; nz = 0; nn = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      if (level_o == 2'b01) np++;
      else if (level_o == 2'b00) nz++;
      else if (level_o == 2'b11) nn++;
    end
  endtask

  // gap between s1 falling and s1n rising, then s1n falling and s1 rising
  task automatic measure_gaps(input int exp_dt);
    int gap;
    int lvl_bad;
    int per;
    bit prev;
    prev = s1_o;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i);
      if (prev && !s1_o) break;
      prev = s1_o;
    end
    gap = 0; lvl_bad = 0;
    while (!s1n_o && gap < 100) begin
      if (level_o != 2'b01) lvl_bad++;
      gap++;
      @(negedge clk_i);
    end
    check("R6 s1 off to s1n on", gap, exp_dt);
    check("R7 code kept in dead time", lvl_bad, 0);
    prev = s1n_o;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i);
      if (prev && !s1n_o) break;
      prev = s1n_o;
    end
    gap = 0;
    while (!s1_o && gap < 100) begin
      gap++;
      @(negedge clk_i);
    end
    check("R6 s1n off to s1 on", gap, exp_dt);
    // R1: one s1 fall to the next equals 2P cycles
    prev = s1_o;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i);
      if (prev && !s1_o) break;
      prev = s1_o;
    end
    per = 0;
    prev = s1_o;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i);
      per++;
      if (prev && !s1_o) break;
      prev = s1_o;
    end
    check("R1 carrier period", per, 2 * int'(period_i));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    int np, nz, nn;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 gates off in reset", int'({s1_o, s2_o, s1n_o, s2n_o}), 0);
    check("R9 code in reset", int'(level_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R9 R3 neutral after reset", int'({s1_o, s2_o, s1n_o, s2n_o}), 4'b0110);

    // R2 R3 R4 R10 R1 vector table
    for (int i = 0; i < NV; i++) begin
      ref_i    = REF_W'(TBL[i][0]);
      period_i = CNT_W'(TBL[i][1]);
      dead_i   = DT_W'(TBL[i][2]);
      repeat (12 * TBL[i][1] + 8) @(negedge clk_i);
      count_levels(2 * TBL[i][1], np, nz, nn);
      check($sformatf("R2 R10 positive cycles vec %0d", i), np, TBL[i][3]);
      check($sformatf("R3 neutral cycles vec %0d", i), nz, TBL[i][4]);
      check($sformatf("R4 R10 negative cycles vec %0d", i), nn, TBL[i][5]);
    end

    // R6 dead time, nonzero and zero
    ref_i = 12'sd4; period_i = CNT_W'(8); dead_i = DT_W'(3);
    repeat (100) @(negedge clk_i);
    measure_gaps(3);
    dead_i = '0;
    repeat (40) @(negedge clk_i);
    measure_gaps(0);

    // R8 reference changing every cycle is sampled only at peaks
    dead_i = DT_W'(1);
    toggle_on = 1'b1;
    repeat (100) @(negedge clk_i);
    count_levels(16, np, nz, nn);
    check("R8 single level while input toggles", ((np == 16) || (nn == 16)) ? 1 : 0, 1);
    toggle_on = 1'b0;

    // R9 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R9 gates off on reset", int'({s1_o, s2_o, s1n_o, s2n_o}), 0);
    check("R9 code zero on reset", int'(level_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    check("R5 R7 no overlap or bad code", shoot, 0);
    done = 1'b1;
    report();
  end
endmodule